// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block is the transmit side of a frame DMA engine. It follows a linked chain of four-word descriptors kept in memory and reaches that memory through a 32-bit request port. Each descriptor holds a control word, a buffer byte address, a status-and-length word and a link to the next descriptor. The walker only works on descriptors whose ownership bit gives them to the controller. For each one it streams the buffer bytes out on a valid/ready byte channel, writes back the completion status, hands the descriptor back to software and follows the link. The first descriptor that software still owns stops the walk.

Software starts a walk by pulsing `poll_req` while `tx_enable` is high. The internal descriptor pointer resets to all ones. While it holds that value a walk starts at `list_base`. Otherwise a walk starts at the descriptor where the previous walk stopped. Completion, unavailable-descriptor and bus-error conditions appear as one-cycle event pulses.

The byte channel follows the usual valid/ready rules. A byte transfers on a rising edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the byte and its last flag stay unchanged. The memory port also uses a request/grant handshake. A request and its address and data stay unchanged until `mem_gnt`. Exactly one response (`mem_rvalid`, with `mem_err` for a failed access) follows each grant, at the earliest one cycle later, and only one access is outstanding at any time.

Top module: `txdesc_walker`

## Requirements
- R1: After reset `cur_desc` is all ones, `busy` is low, and `mem_req` and `tx_valid` are low.
- R2: A `poll_req` pulse while `tx_enable` is low is ignored: no memory request is issued and `busy` stays low.
- R3: A walk starts at `list_base` when `cur_desc` is all ones, and otherwise at `cur_desc`.
- R4: A descriptor at byte address A is read as four words in this order: control word at A, buffer address at A+4, status-and-length at A+8, next-descriptor address at A+12.
- R5: A frame's bytes come out in address order, starting at the buffer address. The byte at address a is bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at a with its two low bits cleared. Exactly the length in status bits [15:0] is sent, and `tx_last` is high only on the final byte. A length of zero sends no bytes.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R7: After the frame, status is written to A+8 first: bits [15:0] keep the length, bit 19 is set, bit 16 is set only if control bit 2 was set, and all other bits are zero. Then the control word is written to A with bit 31 cleared and the other bits kept.
- R8: Each completed frame raises one single-cycle pulse on `ev_txcp` and one on `ev_txintr`.
- R9: A control word with bit 31 clear (software-owned) ends the walk with a single `ev_tdu` pulse. `busy` drops and `cur_desc` holds that descriptor's address.
- R10: A later poll restarts at the stopped descriptor's address and processes it once software has set its bit 31.
- R11: An error response on any access ends the walk with a single `ev_txberr` pulse. No further access is made, no write-back takes place for the current descriptor, and `cur_desc` keeps its address.
- R12: A memory request that is not granted stays asserted with unchanged address in the next cycle.
- R13: A control word with bit 31 set is processed, and `cur_desc` moves to the next-descriptor address once that descriptor's control write-back completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Transmit enable; qualifies poll requests |
| poll_req | input | 1 | One-cycle poll-demand pulse |
| list_base | input | 32 | Start address of the descriptor chain |
| cur_desc | output | 32 | Address of the current descriptor (all ones = none) |
| busy | output | 1 | High while a walk is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Response for the outstanding access |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Response carries an error |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| ev_txcp | output | 1 | Frame-complete pulse |
| ev_txintr | output | 1 | Transmit-interrupt pulse |
| ev_tdu | output | 1 | Descriptor-unavailable pulse |
| ev_txberr | output | 1 | Bus-error pulse |

## Verification
A poll pulse is seen at the next rising edge, and the first descriptor request appears one cycle later. Each response is used at the edge where `mem_rvalid` is high. The event pulses are registered, so each one appears in the cycle after the response that causes it. Because of that, the bench counts pulses and stream bytes in edge-triggered monitors and compares only once `busy` has been sampled low at a falling edge. Memory contents, `cur_desc` and the access log are read at that same falling edge. The ignored-poll and post-error checks watch the access log for twenty further cycles to confirm that nothing moves.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W   = 32;
  localparam int OWN_BIT  = 31;
  localparam int IE_BIT   = 2;
  localparam int DONE_BIT = 19;
  localparam int IRQ_BIT  = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_FLAGS, S_BUF, S_STAT, S_NEXT,
    S_DATA, S_SEND, S_WBSTAT, S_WBFLAGS
  } wstate_t;
endpackage

// File: rtl/txd_lane_sel.sv
module txd_lane_sel
  import txd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        lane,
  output logic [7:0]        byte_out
);
  localparam int LANES = WORD_W / 8;
  logic [7:0] lanes_a [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes_a[g] = word[g*8 +: 8];
  end

  assign byte_out = lanes_a[lane];
endmodule

// File: rtl/txd_wb_fmt.sv
module txd_wb_fmt
  import txd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [WORD_W-1:0] ctrl_in,
  input  logic [WORD_W-1:0] stat_in,
  output logic [WORD_W-1:0] stat_out,
  output logic [WORD_W-1:0] ctrl_out
);
  logic [WORD_W-1:0] len_part;

  assign len_part = WORD_W'(stat_in[LEN_W-1:0]);

  always_comb begin
    stat_out           = len_part;
    stat_out[DONE_BIT] = 1'b1;
    stat_out[IRQ_BIT]  = ctrl_in[IE_BIT];
    ctrl_out           = ctrl_in;
    ctrl_out[OWN_BIT]  = 1'b0;
  end
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              poll_req,
  input  logic [AW-1:0]     list_base,
  output logic [AW-1:0]     cur_desc,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              ev_txcp,
  output logic              ev_txintr,
  output logic              ev_tdu,
  output logic              ev_txberr
);
  localparam logic [AW-1:0] NONE   = {AW{1'b1}};
  localparam logic [AW-1:0] OFS_BA = AW'(4);
  localparam logic [AW-1:0] OFS_ST = AW'(8);
  localparam logic [AW-1:0] OFS_NX = AW'(12);

  wstate_t           state;
  logic              pend;
  logic [WORD_W-1:0] d_ctrl, d_stat, word_buf;
  logic [AW-1:0]     d_next, ptr;
  logic [LEN_W-1:0]  remain;
  logic              frame_done;
  logic [WORD_W-1:0] stat_wb, ctrl_wb;
  logic              is_access;

  txd_lane_sel u_lane (
    .word     (word_buf),
    .lane     (ptr[1:0]),
    .byte_out (tx_data)
  );

  txd_wb_fmt #(.LEN_W(LEN_W)) u_fmt (
    .ctrl_in  (d_ctrl),
    .stat_in  (d_stat),
    .stat_out (stat_wb),
    .ctrl_out (ctrl_wb)
  );

  assign busy      = (state != S_IDLE);
  assign is_access = busy && (state != S_SEND);
  assign mem_req   = is_access && !pend;
  assign mem_we    = (state == S_WBSTAT) || (state == S_WBFLAGS);
  assign mem_wdata = (state == S_WBSTAT) ? stat_wb : ctrl_wb;
  assign tx_valid  = (state == S_SEND);
  assign tx_last   = (state == S_SEND) && (remain == LEN_W'(1));
  assign ev_txcp   = frame_done;
  assign ev_txintr = frame_done;

  always_comb begin
    unique case (state)
      S_BUF:    mem_addr = cur_desc + OFS_BA;
      S_STAT:   mem_addr = cur_desc + OFS_ST;
      S_NEXT:   mem_addr = cur_desc + OFS_NX;
      S_DATA:   mem_addr = {ptr[AW-1:2], 2'b00};
      S_WBSTAT: mem_addr = cur_desc + OFS_ST;
      default:  mem_addr = cur_desc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pend       <= 1'b0;
      cur_desc   <= NONE;
      d_ctrl     <= '0;
      d_stat     <= '0;
      d_next     <= '0;
      ptr        <= '0;
      remain     <= '0;
      word_buf   <= '0;
      frame_done <= 1'b0;
      ev_tdu     <= 1'b0;
      ev_txberr  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      ev_tdu     <= 1'b0;
      ev_txberr  <= 1'b0;
      if (mem_req && mem_gnt) pend <= 1'b1;
      if (state == S_IDLE) begin
        if (poll_req && tx_enable) begin
          if (cur_desc == NONE) cur_desc <= list_base;
          state <= S_FLAGS;
        end
      end else if (state == S_SEND) begin
        if (tx_ready) begin
          ptr    <= ptr + AW'(1);
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1))  state <= S_WBSTAT;
          else if (ptr[1:0] == 2'b11) state <= S_DATA;
        end
      end else if (pend && mem_rvalid) begin
        pend <= 1'b0;
        if (mem_err) begin
          ev_txberr <= 1'b1;
          state     <= S_IDLE;
        end else begin
          unique case (state)
            S_FLAGS: begin
              if (!mem_rdata[OWN_BIT]) begin
                ev_tdu <= 1'b1;
                state  <= S_IDLE;
              end else begin
                d_ctrl <= mem_rdata;
                state  <= S_BUF;
              end
            end
            S_BUF: begin
              ptr   <= mem_rdata[AW-1:0];
              state <= S_STAT;
            end
            S_STAT: begin
              d_stat <= mem_rdata;
              remain <= mem_rdata[LEN_W-1:0];
              state  <= S_NEXT;
            end
            S_NEXT: begin
              d_next <= mem_rdata[AW-1:0];
              state  <= (remain == '0) ? S_WBSTAT : S_DATA;
            end
            S_DATA: begin
              word_buf <= mem_rdata;
              state    <= S_SEND;
            end
            S_WBSTAT: state <= S_WBFLAGS;
            S_WBFLAGS: begin
              cur_desc   <= d_next;
              frame_done <= 1'b1;
              state      <= S_FLAGS;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R6
  AST_TDU_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tdu |-> !busy && !mem_req); // R9
  AST_BERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txberr |-> !busy && !mem_req && !tx_valid); // R11
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_txcp, ev_tdu, ev_txberr})); // R8
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txcp |=> !ev_txcp); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid); // R1
endmodule

// File: tb/txdesc_walker_test.sv
module txdesc_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_enable = 1'b0;
  logic        poll_req = 1'b0;
  logic [31:0] list_base = 32'h100;
  logic [31:0] cur_desc, mem_addr, mem_wdata, mem_rdata;
  logic        busy, mem_req, mem_we, mem_gnt, mem_rvalid, mem_err;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;
  logic        ev_txcp, ev_txintr, ev_tdu, ev_txberr;

  int n_checks = 0;
  int n_fail = 0;

  logic [31:0] mem [256];
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  logic        stall_mode = 1'b0;
  int          cyc = 0;

  logic [31:0] acc_addr [256];
  logic        acc_we   [256];
  int          nacc = 0;
  logic [7:0]  cap      [256];
  logic        cap_last [256];
  int          ncap = 0;
  int          n_cp = 0, n_ir = 0, n_tdu = 0, n_berr = 0;

  always #10 clk = ~clk;

  assign mem_gnt  = stall_mode ? cyc[0] : 1'b1;
  assign tx_ready = stall_mode ? (cyc[1:0] != 2'b00) : 1'b1;

  txdesc_walker uut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .poll_req(poll_req),
    .list_base(list_base), .cur_desc(cur_desc), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .ev_txcp(ev_txcp), .ev_txintr(ev_txintr), .ev_tdu(ev_tdu),
    .ev_txberr(ev_txberr)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (mem_req && mem_gnt) begin
      mem_rvalid <= 1'b1;
      mem_err    <= (mem_addr == err_addr);
      mem_rdata  <= mem[mem_addr[9:2]];
      if (mem_we && mem_addr != err_addr) mem[mem_addr[9:2]] <= mem_wdata;
      if (nacc < 256) begin
        acc_addr[nacc] <= mem_addr;
        acc_we[nacc]   <= mem_we;
      end
      nacc <= nacc + 1;
    end
    if (tx_valid && tx_ready) begin
      if (ncap < 256) begin
        cap[ncap]      <= tx_data;
        cap_last[ncap] <= tx_last;
      end
      ncap <= ncap + 1;
    end
    if (ev_txcp)   n_cp   <= n_cp + 1;
    if (ev_txintr) n_ir   <= n_ir + 1;
    if (ev_tdu)    n_tdu  <= n_tdu + 1;
    if (ev_txberr) n_berr <= n_berr + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, input logic [31:0] b,
                          input logic [31:0] s, input logic [31:0] n);
    mem[a/4] = c; mem[a/4+1] = b; mem[a/4+2] = s; mem[a/4+3] = n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_enable = 1'b0;
    stall_mode = 1'b0;
    err_addr = 32'hFFFF_FFF0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic poll_and_wait();
    @(negedge clk) poll_req = 1'b1;
    @(negedge clk) poll_req = 1'b0;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int first, input int base, input int len);
    for (int i = 0; i < len; i++) begin
      check(req, {24'h0, cap[first+i]}, {24'h0, pat(base+i)});
      check("R5 last", {31'h0, cap_last[first+i]}, {31'h0, (i == len-1)});
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 cur_desc", cur_desc, 32'hFFFF_FFFF);
    check("R1 busy/req/valid", {29'h0, busy, mem_req, tx_valid}, 32'h0);
  endtask

  task automatic t_poll_disabled();
    int na;
    fill_mem();
    do_reset();
    put_desc(32'h100, 32'h8000_0000, 32'h200, 32'd4, 32'h110);
    na = nacc;
    @(negedge clk) poll_req = 1'b1;
    @(negedge clk) poll_req = 1'b0;
    repeat (20) @(negedge clk);
    check("R2 no access", nacc, na);
    check("R2 busy", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_two_frames();
    int na, nc, cp, ir, td, iw_st, iw_fl;
    fill_mem();
    do_reset();
    put_desc(32'h100, 32'h8000_0000, 32'h200, 32'h00AB_0006, 32'h110);
    put_desc(32'h110, 32'h8000_0004, 32'h243, 32'h0000_0011, 32'h120);
    put_desc(32'h120, 32'h0000_0000, 32'h280, 32'h0000_0005, 32'h130);
    put_desc(32'h130, 32'h0000_0000, 32'h0,   32'h0,         32'h0);
    tx_enable = 1'b1;
    na = nacc; nc = ncap; cp = n_cp; ir = n_ir; td = n_tdu;
    poll_and_wait();
    check("R3 start at base", acc_addr[na], 32'h100);
    check("R4 word1", acc_addr[na+1], 32'h104);
    check("R4 word2", acc_addr[na+2], 32'h108);
    check("R4 word3", acc_addr[na+3], 32'h10C);
    check("R5 byte count", ncap - nc, 23);
    check_frame("R5 frame0", nc, 32'h200, 6);
    check_frame("R5 frame1 unaligned", nc + 6, 32'h243, 17);
    check("R7 status0", mem[32'h108/4], 32'h0008_0006);
    check("R7 status1", mem[32'h118/4], 32'h0009_0011);
    check("R7 ctrl0", mem[32'h100/4], 32'h0000_0000);
    check("R7 ctrl1", mem[32'h110/4], 32'h0000_0004);
    iw_st = -1; iw_fl = -1;
    for (int i = na; i < nacc && i < 256; i++) begin
      if (acc_we[i] && acc_addr[i] == 32'h108 && iw_st < 0) iw_st = i;
      if (acc_we[i] && acc_addr[i] == 32'h100 && iw_fl < 0) iw_fl = i;
    end
    check("R7 status before ctrl", {31'h0, (iw_st >= 0 && iw_st < iw_fl)}, 32'h1);
    check("R8 txcp pulses", n_cp - cp, 2);
    check("R8 txintr pulses", n_ir - ir, 2);
    check("R9 tdu pulse", n_tdu - td, 1);
    check("R9 cur_desc stop", cur_desc, 32'h120);
    check("R13 ctrl2 untouched", mem[32'h120/4], 32'h0000_0000);
  endtask

  task automatic t_repoll();
    int na, nc, cp;
    mem[32'h120/4] = 32'h8000_0000;
    stall_mode = 1'b1;
    na = nacc; nc = ncap; cp = n_cp;
    poll_and_wait();
    check("R10 refetch same", acc_addr[na], 32'h120);
    check("R10 bytes", ncap - nc, 5);
    check_frame("R6 backpressured frame", nc, 32'h280, 5);
    check("R10 completes", n_cp - cp, 1);
    check("R13 cur_desc advanced", cur_desc, 32'h130);
    stall_mode = 1'b0;
  endtask

  task automatic t_zero_len();
    int nc, cp;
    fill_mem();
    do_reset();
    put_desc(32'h100, 32'h8000_0000, 32'h200, 32'h0000_0000, 32'h110);
    put_desc(32'h110, 32'h0000_0000, 32'h200, 32'h0, 32'h0);
    tx_enable = 1'b1;
    nc = ncap; cp = n_cp;
    poll_and_wait();
    check("R5 zero length no bytes", ncap - nc, 0);
    check("R7 zero length status", mem[32'h108/4], 32'h0008_0000);
    check("R8 zero length complete", n_cp - cp, 1);
    check("R9 stop at second", cur_desc, 32'h110);
  endtask

  task automatic t_bus_error();
    int na, nc, cp, be;
    fill_mem();
    do_reset();
    put_desc(32'h100, 32'h8000_0000, 32'h300, 32'h0000_0004, 32'h110);
    err_addr = 32'h300;
    tx_enable = 1'b1;
    nc = ncap; cp = n_cp; be = n_berr;
    poll_and_wait();
    na = nacc;
    repeat (20) @(negedge clk);
    check("R11 berr pulse", n_berr - be, 1);
    check("R11 no further access", nacc, na);
    check("R11 no complete", n_cp - cp, 0);
    check("R11 no bytes", ncap - nc, 0);
    check("R11 ctrl still owned", mem[32'h100/4], 32'h8000_0000);
    check("R11 cur_desc kept", cur_desc, 32'h100);
  endtask

  initial begin
    fill_mem();
    t_reset_state();
    t_poll_disabled();
    t_two_frames();
    t_repoll();
    t_zero_len();
    t_bus_error();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule